// File: doc/BRIEF.md
# Idle Auto-Sleep Power Controller

This block decides when a storage controller may stop its clocks. Each time a host command finishes, an idle timer starts. If the idle period runs out before another command arrives, the block enters sleep. It then drops its clock-gate enable and raises a sleep indication. The host does nothing to make this happen. The idle period is measured in microseconds. A prescaler parameter sets how many clock cycles make one microsecond. The default idle period is 5 ms, and the host can change it through a small register write port.

Any new command strobe wakes a sleeping device; no reset is needed first. Wake-up holds the busy flag high for a programmable wake latency. The command that caused the wake is held until that latency ends. At that point a one-cycle release pulse tells the command path that it may proceed. The default wake latency is 2000 µs. This stays within both the read bound (2.0 ms) and the write bound (2.5 ms) for leaving sleep.

The controller has four states: `PS_IDLE_WAIT`, `PS_ACTIVE`, `PS_SLEEP` and `PS_WAKING`.
- The idle timer expiring moves `PS_IDLE_WAIT` to `PS_SLEEP`. A command strobe in `PS_IDLE_WAIT` moves it to `PS_ACTIVE` instead.
- A completion pulse in `PS_ACTIVE` moves it to `PS_IDLE_WAIT`.
- A command strobe in `PS_SLEEP` moves it to `PS_WAKING`.
- The wake timer expiring moves `PS_WAKING` to `PS_ACTIVE`.

Each timer restarts from zero every time its state is entered.

Top module: `idle_sleep_ctrl`

## Requirements
- R1: After reset the block is awake (`asleep`=0, `clk_en`=1, `busy`=0, `cmd_release`=0) and in the idle-wait state. The idle limit is reset to IDLE_DEFAULT_US and the wake limit to WAKE_DEFAULT_US.
- R2: Suppose the idle-wait state is entered at clock edge E and no command strobe arrives. Then `asleep` rises at edge E + L*TICKS_PER_US + 1, where L is the idle limit in µs.
- R3: A command strobe during idle wait cancels the pending sleep. `cmd_release` pulses in the next cycle. The next completion restarts a full idle period.
- R4: A command strobe while asleep clears `asleep` and sets `busy` at the next edge. `busy` stays high for W*TICKS_PER_US + 1 cycles, where W is the wake limit in µs. It then falls together with a one-cycle `cmd_release` pulse.
- R5: Command strobes during wake-up, and completion pulses outside the active state, change neither the outputs nor the wake timing.
- R6: In the active state, a command strobe in the same cycle as a completion pulse wins. The block stays active and pulses `cmd_release`.
- R7: A register write with `cfg_sel`=0 sets the idle limit. A write with `cfg_sel`=1 sets the wake limit. Both limits are in µs and take effect from the cycle after the write.
- R8: An idle limit of 0 puts the block to sleep one cycle after it enters idle wait.
- R9: `clk_en` is always the inverse of `asleep`, and `busy` is never high while `asleep` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_issue | input | 1 | Host command strobe, one cycle |
| cmd_done | input | 1 | Command completion pulse, one cycle |
| cfg_we | input | 1 | Limit register write enable |
| cfg_sel | input | 1 | 0 = idle limit, 1 = wake limit |
| cfg_wdata | input | CNT_W | Limit value in µs |
| asleep | output | 1 | Sleep state indication |
| clk_en | output | 1 | Clock-gate enable for the controller |
| busy | output | 1 | High while waking |
| cmd_release | output | 1 | One-cycle pulse: held command may proceed |

## Verification
The bench builds the block with TICKS_PER_US=4, a 10 µs idle default and a 6 µs wake default. This brings the full default sleep entry (40 cycles) and wake-up (24 cycles) within a few dozen cycles. It still exercises the prescaler rollover on every microsecond. Runtime writes then set limits of 3, 2 and 0 µs. These reach the minimum and zero-limit corners, and the cases where a limit changes while its state is being left or entered.

// File: rtl/idle_sleep_pkg.sv
package idle_sleep_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE    = 2'd0,
        PS_IDLE_WAIT = 2'd1,
        PS_SLEEP     = 2'd2,
        PS_WAKING    = 2'd3
    } pwr_state_t;

    localparam logic CFG_SEL_IDLE = 1'b0;
    localparam logic CFG_SEL_WAKE = 1'b1;

endpackage

// File: rtl/sleep_cfg_regs.sv
module sleep_cfg_regs #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned IDLE_RST = 5000,
    parameter int unsigned WAKE_RST = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] idle_us,
    output logic [CNT_W-1:0] wake_us
);
    import idle_sleep_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_us <= CNT_W'(IDLE_RST);
            wake_us <= CNT_W'(WAKE_RST);
        end else if (we) begin
            if (sel == CFG_SEL_IDLE) idle_us <= wdata;
            else                     wake_us <= wdata;
        end
    end
endmodule

// File: rtl/us_interval_timer.sv
module us_interval_timer #(
    parameter int unsigned TICKS_PER_US = 200,
    parameter int unsigned CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit_us,
    output logic             expired
);
    logic [CNT_W-1:0] us_cnt;
    logic             us_tick;

    generate
        if (TICKS_PER_US > 1) begin : g_prescale
            localparam int unsigned PRE_W = $clog2(TICKS_PER_US);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);
            logic [PRE_W-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  pre_cnt <= '0;
                else if (!run || expired)    pre_cnt <= '0;
                else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
                else                         pre_cnt <= pre_cnt + 1'b1;
            end
            assign us_tick = run && !expired && (pre_cnt == PRE_LAST);
        end else begin : g_direct
            assign us_tick = run && !expired;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       us_cnt <= '0;
        else if (!run)    us_cnt <= '0;
        else if (us_tick) us_cnt <= us_cnt + 1'b1;
    end

    assign expired = run && (us_cnt >= limit_us);

    // R2
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && expired |=> !run || $stable(us_cnt));
endmodule

// File: rtl/idle_sleep_ctrl.sv
module idle_sleep_ctrl #(
    parameter int unsigned TICKS_PER_US    = 200,
    parameter int unsigned CNT_W           = 16,
    parameter int unsigned IDLE_DEFAULT_US = 5000,
    parameter int unsigned WAKE_DEFAULT_US = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_issue,
    input  logic             cmd_done,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic             asleep,
    output logic             clk_en,
    output logic             busy,
    output logic             cmd_release
);
    import idle_sleep_pkg::*;

    pwr_state_t       state, state_nxt;
    logic [CNT_W-1:0] idle_us, wake_us;
    logic             idle_exp, wake_exp;
    logic             release_d;

    sleep_cfg_regs #(
        .CNT_W    (CNT_W),
        .IDLE_RST (IDLE_DEFAULT_US),
        .WAKE_RST (WAKE_DEFAULT_US)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .idle_us (idle_us),
        .wake_us (wake_us)
    );

    us_interval_timer #(.TICKS_PER_US(TICKS_PER_US), .CNT_W(CNT_W)) u_idle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == PS_IDLE_WAIT),
        .limit_us (idle_us),
        .expired  (idle_exp)
    );

    us_interval_timer #(.TICKS_PER_US(TICKS_PER_US), .CNT_W(CNT_W)) u_wake_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == PS_WAKING),
        .limit_us (wake_us),
        .expired  (wake_exp)
    );

    always_comb begin
        state_nxt = state;
        release_d = 1'b0;
        unique case (state)
            PS_IDLE_WAIT: begin
                if (cmd_issue) begin
                    state_nxt = PS_ACTIVE;
                    release_d = 1'b1;
                end else if (idle_exp) begin
                    state_nxt = PS_SLEEP;
                end
            end
            PS_ACTIVE: begin
                if (cmd_issue)     release_d = 1'b1;
                else if (cmd_done) state_nxt = PS_IDLE_WAIT;
            end
            PS_SLEEP: begin
                if (cmd_issue) state_nxt = PS_WAKING;
            end
            PS_WAKING: begin
                if (wake_exp) begin
                    state_nxt = PS_ACTIVE;
                    release_d = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= PS_IDLE_WAIT;
            cmd_release <= 1'b0;
        end else begin
            state       <= state_nxt;
            cmd_release <= release_d;
        end
    end

    always_comb begin
        asleep = (state == PS_SLEEP);
        clk_en = (state != PS_SLEEP);
        busy   = (state == PS_WAKING);
    end

    // R2
    sleep_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(idle_exp));
    // R4
    wake_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> busy);
    // R4
    busy_ends_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wake_exp) && cmd_release);
    // R4
    sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep && !cmd_issue |=> asleep);
    // R3
    idle_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep && !busy && cmd_issue |=> !asleep && cmd_release);
    // R9
    release_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |-> clk_en && !busy);
endmodule

// File: tb/idle_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module idle_sleep_ctrl_bench;
    localparam int P      = 4;
    localparam int CNT_W  = 16;
    localparam int IDLE_D = 10;
    localparam int WAKE_D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_issue = 1'b0, cmd_done = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic asleep, clk_en, busy, cmd_release;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase = "R1";
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    idle_sleep_ctrl #(
        .TICKS_PER_US(P), .CNT_W(CNT_W),
        .IDLE_DEFAULT_US(IDLE_D), .WAKE_DEFAULT_US(WAKE_D)
    ) u_idle_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_done(cmd_done),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .asleep(asleep), .clk_en(clk_en), .busy(busy), .cmd_release(cmd_release)
    );

    // behavioural reference: 0 active, 1 idle wait, 2 asleep, 3 waking
    int m_mode = 1;
    int m_cnt = 0;
    int m_idle = IDLE_D;
    int m_wake = WAKE_D;
    bit m_rel = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_cnt = 0; m_idle = IDLE_D; m_wake = WAKE_D; m_rel = 0;
        end else begin
            m_rel = 0;
            case (m_mode)
                1: if (cmd_issue) begin m_mode = 0; m_rel = 1; end
                   else if (m_cnt >= m_idle * P) m_mode = 2;
                   else m_cnt++;
                0: if (cmd_issue) m_rel = 1;
                   else if (cmd_done) begin m_mode = 1; m_cnt = 0; end
                2: if (cmd_issue) begin m_mode = 3; m_cnt = 0; end
                default: if (m_cnt >= m_wake * P) begin m_mode = 0; m_rel = 1; end
                         else m_cnt++;
            endcase
            if (cfg_we) begin
                if (cfg_sel) m_wake = int'(cfg_wdata);
                else         m_idle = int'(cfg_wdata);
            end
        end
    end

    task automatic check1(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done_flag) begin
            check1(phase, "asleep", asleep, m_mode == 2);
            check1(phase, "busy", busy, m_mode == 3);
            check1(phase, "cmd_release", cmd_release, m_rel);
            // R9
            check1("R9", "clk_en", clk_en, !asleep);
            check1("R9", "busy_while_asleep", busy && asleep, 1'b0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done_flag) begin
            done_flag = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue();
        @(negedge clk); cmd_issue = 1'b1;
        @(negedge clk); cmd_issue = 1'b0;
    endtask

    task automatic finish_cmd();
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
    endtask

    task automatic cfg_write(logic sel, int val);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = CNT_W'(val);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        phase = "R1";
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);
        // R2: default idle period from reset
        phase = "R2";
        wait_cyc(50);
        // R4: wake from sleep with default latency
        phase = "R4";
        issue();
        wait_cyc(5);
        // R5: strobes during wake and stray completions ignored
        phase = "R5";
        issue();
        finish_cmd();
        wait_cyc(25);
        // R6: strobe beats completion in the same cycle
        phase = "R6";
        @(negedge clk); cmd_issue = 1'b1; cmd_done = 1'b1;
        @(negedge clk); cmd_issue = 1'b0; cmd_done = 1'b0;
        wait_cyc(3);
        finish_cmd();
        // R3: command during idle wait, then full restart
        phase = "R3";
        wait_cyc(20);
        issue();
        wait_cyc(2);
        finish_cmd();
        wait_cyc(48);
        // R7: new limits
        phase = "R7";
        cfg_write(1'b0, 3);
        cfg_write(1'b1, 2);
        issue();
        wait_cyc(12);
        finish_cmd();
        wait_cyc(18);
        // R8: zero idle limit
        phase = "R8";
        cfg_write(1'b0, 0);
        issue();
        wait_cyc(12);
        finish_cmd();
        wait_cyc(6);
        // R5: completion while asleep has no effect
        phase = "R5";
        finish_cmd();
        wait_cyc(4);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule